// File: doc/BRIEF.md
# Dual-Bank Register File with Exchange

This block is the register file of an 8-bit processor core. It keeps an accumulator, a flag byte and six general bytes (B, C, D, E, H, L). Each of these eight bytes has a second copy in a hidden bank. The other bank has no address of its own. The core reaches it only by exchanging banks. One exchange command covers the BC, DE and HL pairs. A second, independent command covers the AF pair. The file also holds four 16-bit pointers (IX, IY, SP, PC) and two 8-bit special bytes (I, R). The flag and ALU logic sit outside this block.

The core reads through two registered ports. A byte port returns any of the ten byte registers, and a word port returns any of the eight 16-bit views. A single write port takes either a byte or a word. A one-cycle fetch strobe advances PC and the refresh counter R. An exchange moves no data: it toggles a bank-select bit for the affected group. The swap therefore completes in one cycle, whatever the register contents are.

Top module: `dual_bank_regfile`

## Requirements
- R1: A synchronous active-high reset clears PC, I and R to zero. It also returns both register groups to their primary bank. The contents of the other registers are left as they were.
- R2: Byte access: with wr_wide=0, wr_sel selects a byte register using codes B=0, C=1, D=2, E=3, H=4, L=5, F=6, A=7, I=8 and R=9. wr_data[7:0] is written to that register. rd8_sel uses the same codes for reads.
- R3: Word access: with wr_wide=1, wr_sel[2:0] selects a word using codes BC=0, DE=1, HL=2, AF=3, IX=4, IY=5, SP=6 and PC=7. rd16_sel uses the same codes. In each pair, the first-named register is the upper byte.
- R4: Both read ports are registered. A read takes the register state from before the clock edge at which it is captured, so a write in the same cycle shows up only on the following read.
- R5: A pulse on xchg_main swaps BC, DE and HL with their hidden copies and leaves AF unchanged. Two pulses restore the original view.
- R6: A pulse on xchg_af swaps only AF with its hidden copy and leaves BC, DE and HL unchanged. Both pulses in the same cycle swap both groups.
- R7: Writes reach only the active bank. The hidden copies keep their values until an exchange exposes them.
- R8: A write in the same cycle as an exchange lands in the bank that was active before that exchange.
- R9: Each fetch pulse adds one to PC, and PC wraps from 0xFFFF to 0x0000.
- R10: Each fetch pulse adds one to the low seven bits of R, wrapping from 0x7F to 0x00 in those bits. Bit 7 of R is left unchanged.
- R11: An explicit write to PC or R in the same cycle as a fetch takes priority over the increment. A fetch does not change I.
- R12: IX, IY and SP hold any 16-bit value written to them and return it on read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xchg_main | input | 1 | Exchange BC/DE/HL with the hidden bank |
| xchg_af | input | 1 | Exchange AF with the hidden bank |
| fetch | input | 1 | Opcode fetch strobe (PC and R increment) |
| wr_en | input | 1 | Write enable |
| wr_wide | input | 1 | 1 = word write, 0 = byte write |
| wr_sel | input | 4 | Write target code |
| wr_data | input | 16 | Write data (low byte used for byte writes) |
| rd8_sel | input | 4 | Byte read code |
| rd8_data | output | 8 | Registered byte read data |
| rd16_sel | input | 3 | Word read code |
| rd16_data | output | 16 | Registered word read data |

## Verification
The hardest case to reach from the ports is a write that arrives in the same cycle as an exchange. The question there is which physical copy receives the data, and the hidden copy cannot be read directly. The bench first loads distinct values into both banks, switching banks with exchanges in between. It then issues the write together with an exchange. Reading the register right away shows the other bank's old value. A second exchange then shows where the write landed. A reset taken while both groups point at the hidden bank is checked the same way, through the values that become visible afterwards.

// File: rtl/regfile_pkg.sv
package regfile_pkg;
  typedef enum logic [3:0] {
    SEL_B = 4'd0, SEL_C = 4'd1, SEL_D = 4'd2, SEL_E = 4'd3,
    SEL_H = 4'd4, SEL_L = 4'd5, SEL_F = 4'd6, SEL_A = 4'd7,
    SEL_I = 4'd8, SEL_R = 4'd9
  } byte_sel_e;

  typedef enum logic [2:0] {
    WSEL_BC = 3'd0, WSEL_DE = 3'd1, WSEL_HL = 3'd2, WSEL_AF = 3'd3,
    WSEL_IX = 3'd4, WSEL_IY = 3'd5, WSEL_SP = 3'd6, WSEL_PC = 3'd7
  } word_sel_e;

  localparam int NUM_PAIRS = 4;
  localparam int NUM_PTRS  = 4;
  localparam int AF_SLOT   = 3;
endpackage

// File: rtl/rf_bank_ctrl.sv
module rf_bank_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic xchg_main,
  input  logic xchg_af,
  output logic sel_main,
  output logic sel_af
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sel_main <= 1'b0;
      sel_af   <= 1'b0;
    end else begin
      if (xchg_main) sel_main <= ~sel_main;
      if (xchg_af)   sel_af   <= ~sel_af;
    end
  end

  // R5: each main exchange flips the group's bank
  a_r5_main_flip: assert property (@(posedge clk) disable iff (rst)
    xchg_main |=> sel_main != $past(sel_main));
  // R5: no main exchange, no main bank change
  a_r5_main_hold: assert property (@(posedge clk) disable iff (rst)
    !xchg_main |=> $stable(sel_main));
  // R6: AF bank changes only on its own command
  a_r6_af_hold: assert property (@(posedge clk) disable iff (rst)
    !xchg_af |=> $stable(sel_af));
  a_r6_af_flip: assert property (@(posedge clk) disable iff (rst)
    xchg_af |=> sel_af != $past(sel_af));
endmodule

// File: rtl/rf_pair_bank.sv
module rf_pair_bank #(
  parameter int BYTE_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bank_sel,
  input  logic                  wr_hi,
  input  logic                  wr_lo,
  input  logic [2*BYTE_W-1:0]   wr_val,
  output logic [2*BYTE_W-1:0]   cur
);
  logic [BYTE_W-1:0] hi_mem [0:1];
  logic [BYTE_W-1:0] lo_mem [0:1];
  logic [BYTE_W-1:0] idle_hi, idle_lo;

  always_ff @(posedge clk) begin
    if (wr_hi) hi_mem[bank_sel] <= wr_val[2*BYTE_W-1:BYTE_W];
  end

  always_ff @(posedge clk) begin
    if (wr_lo) lo_mem[bank_sel] <= wr_val[BYTE_W-1:0];
  end

  assign cur     = {hi_mem[bank_sel], lo_mem[bank_sel]};
  assign idle_hi = hi_mem[~bank_sel];
  assign idle_lo = lo_mem[~bank_sel];

  // R7: while the bank stays put, the hidden copy never changes
  a_r7_hidden_hi: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (bank_sel != $past(bank_sel)) || (idle_hi == $past(idle_hi)));
  a_r7_hidden_lo: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (bank_sel != $past(bank_sel)) || (idle_lo == $past(idle_lo)));
endmodule

// File: rtl/rf_special.sv
module rf_special #(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                fetch,
  input  logic [3:0]          wr_ptr,
  input  logic                wr_i,
  input  logic                wr_r,
  input  logic [2*BYTE_W-1:0] wv,
  input  logic [BYTE_W-1:0]   bv,
  output logic [2*BYTE_W-1:0] ix,
  output logic [2*BYTE_W-1:0] iy,
  output logic [2*BYTE_W-1:0] sp,
  output logic [2*BYTE_W-1:0] pc,
  output logic [BYTE_W-1:0]   ireg,
  output logic [BYTE_W-1:0]   rreg
);
  always_ff @(posedge clk) begin
    if (wr_ptr[0]) ix <= wv;
    if (wr_ptr[1]) iy <= wv;
    if (wr_ptr[2]) sp <= wv;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc   <= '0;
      ireg <= '0;
      rreg <= '0;
    end else begin
      if (wr_ptr[3])  pc <= wv;
      else if (fetch) pc <= pc + 1'b1;
      if (wr_i) ireg <= bv;
      if (wr_r)       rreg <= bv;
      else if (fetch) rreg <= {rreg[BYTE_W-1], rreg[BYTE_W-2:0] + 1'b1};
    end
  end

  a_r9_pc_step: assert property (@(posedge clk) disable iff (rst)
    (fetch && !wr_ptr[3]) |=> pc == $past(pc) + 1'b1);
  a_r10_refresh_step: assert property (@(posedge clk) disable iff (rst)
    (fetch && !wr_r) |=> (rreg[BYTE_W-1] == $past(rreg[BYTE_W-1])) &&
                         (rreg[BYTE_W-2:0] == $past(rreg[BYTE_W-2:0]) + 1'b1));
  a_r11_pc_write_wins: assert property (@(posedge clk) disable iff (rst)
    wr_ptr[3] |=> pc == $past(wv));
  a_r11_i_fetch_hold: assert property (@(posedge clk) disable iff (rst)
    !wr_i |=> $stable(ireg));
endmodule

// File: rtl/dual_bank_regfile.sv
module dual_bank_regfile
  import regfile_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                xchg_main,
  input  logic                xchg_af,
  input  logic                fetch,
  input  logic                wr_en,
  input  logic                wr_wide,
  input  logic [3:0]          wr_sel,
  input  logic [2*BYTE_W-1:0] wr_data,
  input  logic [3:0]          rd8_sel,
  output logic [BYTE_W-1:0]   rd8_data,
  input  logic [2:0]          rd16_sel,
  output logic [2*BYTE_W-1:0] rd16_data
);
  localparam int WORD_W = 2 * BYTE_W;

  logic                 sel_main, sel_af;
  logic [NUM_PAIRS-1:0] pw_hi, pw_lo;
  logic [NUM_PTRS-1:0]  ptr_wr;
  logic                 wr_i, wr_r;
  logic [WORD_W-1:0]    pair_wv;
  logic [WORD_W-1:0]    pair_cur [NUM_PAIRS];
  logic [WORD_W-1:0]    ix, iy, sp, pc;
  logic [BYTE_W-1:0]    ireg, rreg;
  logic [BYTE_W-1:0]    rd8_next;
  logic [WORD_W-1:0]    rd16_next;

  rf_bank_ctrl u_bank_ctrl (
    .clk(clk), .rst(rst), .xchg_main(xchg_main), .xchg_af(xchg_af),
    .sel_main(sel_main), .sel_af(sel_af)
  );

  assign pair_wv = wr_wide ? wr_data : {wr_data[BYTE_W-1:0], wr_data[BYTE_W-1:0]};

  always_comb begin
    pw_hi  = '0;
    pw_lo  = '0;
    ptr_wr = '0;
    wr_i   = 1'b0;
    wr_r   = 1'b0;
    if (wr_en) begin
      if (wr_wide) begin
        if (wr_sel[2]) ptr_wr[wr_sel[1:0]] = 1'b1;
        else begin
          pw_hi[wr_sel[1:0]] = 1'b1;
          pw_lo[wr_sel[1:0]] = 1'b1;
        end
      end else begin
        case (byte_sel_e'(wr_sel))
          SEL_B:   pw_hi[0] = 1'b1;
          SEL_C:   pw_lo[0] = 1'b1;
          SEL_D:   pw_hi[1] = 1'b1;
          SEL_E:   pw_lo[1] = 1'b1;
          SEL_H:   pw_hi[2] = 1'b1;
          SEL_L:   pw_lo[2] = 1'b1;
          SEL_F:   pw_lo[AF_SLOT] = 1'b1;
          SEL_A:   pw_hi[AF_SLOT] = 1'b1;
          SEL_I:   wr_i = 1'b1;
          SEL_R:   wr_r = 1'b1;
          default: ;
        endcase
      end
    end
  end

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    localparam bit IS_AF = (p == AF_SLOT);
    rf_pair_bank #(.BYTE_W(BYTE_W)) u_pair (
      .clk(clk), .rst(rst),
      .bank_sel(IS_AF ? sel_af : sel_main),
      .wr_hi(pw_hi[p]), .wr_lo(pw_lo[p]),
      .wr_val(pair_wv), .cur(pair_cur[p])
    );
  end

  rf_special #(.BYTE_W(BYTE_W)) u_special (
    .clk(clk), .rst(rst), .fetch(fetch), .wr_ptr(ptr_wr),
    .wr_i(wr_i), .wr_r(wr_r), .wv(wr_data), .bv(wr_data[BYTE_W-1:0]),
    .ix(ix), .iy(iy), .sp(sp), .pc(pc), .ireg(ireg), .rreg(rreg)
  );

  always_comb begin
    case (byte_sel_e'(rd8_sel))
      SEL_B:   rd8_next = pair_cur[0][WORD_W-1:BYTE_W];
      SEL_C:   rd8_next = pair_cur[0][BYTE_W-1:0];
      SEL_D:   rd8_next = pair_cur[1][WORD_W-1:BYTE_W];
      SEL_E:   rd8_next = pair_cur[1][BYTE_W-1:0];
      SEL_H:   rd8_next = pair_cur[2][WORD_W-1:BYTE_W];
      SEL_L:   rd8_next = pair_cur[2][BYTE_W-1:0];
      SEL_F:   rd8_next = pair_cur[AF_SLOT][BYTE_W-1:0];
      SEL_A:   rd8_next = pair_cur[AF_SLOT][WORD_W-1:BYTE_W];
      SEL_I:   rd8_next = ireg;
      SEL_R:   rd8_next = rreg;
      default: rd8_next = '0;
    endcase
  end

  always_comb begin
    case (word_sel_e'(rd16_sel))
      WSEL_BC: rd16_next = pair_cur[0];
      WSEL_DE: rd16_next = pair_cur[1];
      WSEL_HL: rd16_next = pair_cur[2];
      WSEL_AF: rd16_next = pair_cur[AF_SLOT];
      WSEL_IX: rd16_next = ix;
      WSEL_IY: rd16_next = iy;
      WSEL_SP: rd16_next = sp;
      default: rd16_next = pc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd8_data  <= '0;
      rd16_data <= '0;
    end else begin
      rd8_data  <= rd8_next;
      rd16_data <= rd16_next;
    end
  end

  // R4: word port returns the pre-edge PC
  a_r4_pc_read_latency: assert property (@(posedge clk) disable iff (rst)
    (rd16_sel == 3'd7) |=> rd16_data == $past(pc));
endmodule

// File: tb/dual_bank_regfile_tb.sv
module dual_bank_regfile_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        xchg_main = 1'b0, xchg_af = 1'b0, fetch = 1'b0;
  logic        wr_en = 1'b0, wr_wide = 1'b0;
  logic [3:0]  wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic [3:0]  rd8_sel = '0;
  logic [7:0]  rd8_data;
  logic [2:0]  rd16_sel = '0;
  logic [15:0] rd16_data;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_bank_regfile #(.BYTE_W(8)) dut_i (
    .clk(clk), .rst(rst), .xchg_main(xchg_main), .xchg_af(xchg_af),
    .fetch(fetch), .wr_en(wr_en), .wr_wide(wr_wide), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd8_sel(rd8_sel), .rd8_data(rd8_data),
    .rd16_sel(rd16_sel), .rd16_data(rd16_data)
  );

  task automatic tick(); @(negedge clk); endtask

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr8(input logic [3:0] s, input logic [7:0] v);
    wr_en = 1; wr_wide = 0; wr_sel = s; wr_data = {8'h00, v};
    tick(); wr_en = 0;
  endtask

  task automatic wr16(input logic [2:0] s, input logic [15:0] v);
    wr_en = 1; wr_wide = 1; wr_sel = {1'b0, s}; wr_data = v;
    tick(); wr_en = 0;
  endtask

  task automatic rd8(input logic [3:0] s, output logic [7:0] v);
    rd8_sel = s; tick(); v = rd8_data;
  endtask

  task automatic rd16(input logic [2:0] s, output logic [15:0] v);
    rd16_sel = s; tick(); v = rd16_data;
  endtask

  task automatic xm(); xchg_main = 1; tick(); xchg_main = 0; endtask
  task automatic xa(); xchg_af = 1; tick(); xchg_af = 0; endtask
  task automatic fe(); fetch = 1; tick(); fetch = 0; endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0]  b;
    logic [15:0] w;
    logic [3:0]  hic [4];
    logic [3:0]  loc [4];
    hic[0] = 4'd0; hic[1] = 4'd2; hic[2] = 4'd4; hic[3] = 4'd7;
    loc[0] = 4'd1; loc[1] = 4'd3; loc[2] = 4'd5; loc[3] = 4'd6;

    repeat (3) tick();
    rst = 0;

    // R1: reset state of PC, I, R
    rd16(3'd7, w); chk("R1 pc", w, 16'h0000);
    rd8(4'd8, b);  chk("R1 i", {8'h0, b}, 16'h0000);
    rd8(4'd9, b);  chk("R1 r", {8'h0, b}, 16'h0000);

    // R2: byte sweep over all ten byte registers
    for (int k = 0; k < 8; k++) begin
      for (int s = 0; s < 10; s++) wr8(4'(s), 8'((s * 29 + k * 71 + 3) & 8'hFF));
      for (int s = 0; s < 10; s++) begin
        rd8(4'(s), b);
        chk("R2 byte", {8'h0, b}, 16'((s * 29 + k * 71 + 3) & 8'hFF));
      end
    end

    // R3: word writes split into bytes, byte writes merge into words
    for (int p = 0; p < 4; p++) begin
      w = 16'h1234 + 16'(p) * 16'h1111;
      wr16(3'(p), w);
      rd8(hic[p], b); chk("R3 hi", {8'h0, b}, {8'h0, w[15:8]});
      rd8(loc[p], b); chk("R3 lo", {8'h0, b}, {8'h0, w[7:0]});
      wr8(hic[p], 8'(8'hC0 + p));
      wr8(loc[p], 8'(8'h0D + p));
      rd16(3'(p), w); chk("R3 word", w, {8'(8'hC0 + p), 8'(8'h0D + p)});
    end

    // R12: pointer registers
    for (int k = 0; k < 16; k++) begin
      for (int p = 4; p < 7; p++) begin
        wr16(3'(p), 16'(k * 16'h1357 + p * 16'h0F0F) ^ 16'hA5C3);
        rd16(3'(p), w);
        chk("R12 ptr", w, 16'(k * 16'h1357 + p * 16'h0F0F) ^ 16'hA5C3);
      end
    end

    // R5 / R7: main exchange
    wr16(3'd0, 16'hA1B2); wr16(3'd1, 16'hC3D4); wr16(3'd2, 16'hE5F6); wr16(3'd3, 16'h0718);
    xm();
    wr16(3'd0, 16'h1122); wr16(3'd1, 16'h3344); wr16(3'd2, 16'h5566);
    rd16(3'd0, w); chk("R5 bc shadow", w, 16'h1122);
    rd16(3'd2, w); chk("R5 hl shadow", w, 16'h5566);
    rd16(3'd3, w); chk("R5 af kept", w, 16'h0718);
    xm();
    rd16(3'd0, w); chk("R7 bc primary", w, 16'hA1B2);
    rd16(3'd1, w); chk("R7 de primary", w, 16'hC3D4);
    rd16(3'd2, w); chk("R7 hl primary", w, 16'hE5F6);
    rd16(3'd3, w); chk("R5 af after", w, 16'h0718);

    // R6: AF exchange
    xa();
    wr16(3'd3, 16'h99AA);
    rd16(3'd0, w); chk("R6 bc kept", w, 16'hA1B2);
    rd16(3'd3, w); chk("R6 af shadow", w, 16'h99AA);
    xa();
    rd16(3'd3, w); chk("R6 af primary", w, 16'h0718);
    xa();
    rd8(4'd7, b);  chk("R6 a shadow", {8'h0, b}, 16'h0099);
    xa();
    rd8(4'd6, b);  chk("R6 f primary", {8'h0, b}, 16'h0018);

    // R8: write together with exchange
    wr_en = 1; wr_wide = 0; wr_sel = 4'd0; wr_data = 16'h005A; xchg_main = 1;
    tick(); wr_en = 0; xchg_main = 0;
    rd8(4'd0, b); chk("R8 b shadow", {8'h0, b}, 16'h0011);
    xm();
    rd8(4'd0, b); chk("R8 b primary", {8'h0, b}, 16'h005A);

    // R6: both exchanges in one cycle
    xchg_main = 1; xchg_af = 1; tick(); xchg_main = 0; xchg_af = 0;
    rd16(3'd0, w); chk("R6 both bc", w, 16'h1122);
    rd16(3'd3, w); chk("R6 both af", w, 16'h99AA);
    xchg_main = 1; xchg_af = 1; tick(); xchg_main = 0; xchg_af = 0;

    // R4: read in the same cycle as a write returns old value
    rd8_sel = 4'd7; wr_en = 1; wr_wide = 0; wr_sel = 4'd7; wr_data = 16'h003C;
    tick(); wr_en = 0;
    chk("R4 old", {8'h0, rd8_data}, 16'h0007);
    tick();
    chk("R4 new", {8'h0, rd8_data}, 16'h003C);

    // R9: PC increments and wraps
    wr16(3'd7, 16'hFFFE);
    fe();
    rd16(3'd7, w); chk("R9 pc step", w, 16'hFFFF);
    fe();
    rd16(3'd7, w); chk("R9 pc wrap", w, 16'h0000);

    // R11: write wins over fetch
    wr_en = 1; wr_wide = 1; wr_sel = 4'd7; wr_data = 16'h4000; fetch = 1;
    tick(); wr_en = 0; fetch = 0;
    rd16(3'd7, w); chk("R11 pc write", w, 16'h4000);

    // R10: refresh counter
    wr8(4'd9, 8'h7E);
    fe(); rd8(4'd9, b); chk("R10 r step", {8'h0, b}, 16'h007F);
    fe(); rd8(4'd9, b); chk("R10 r wrap", {8'h0, b}, 16'h0000);
    wr8(4'd9, 8'hFF);
    fe(); rd8(4'd9, b); chk("R10 r msb", {8'h0, b}, 16'h0080);
    rd16(3'd7, w); chk("R9 pc count", w, 16'h4003);

    // R11: R write beats fetch, I untouched by fetch
    wr8(4'd8, 8'h42);
    wr_en = 1; wr_wide = 0; wr_sel = 4'd9; wr_data = 16'h0010; fetch = 1;
    tick(); wr_en = 0; fetch = 0;
    rd8(4'd9, b); chk("R11 r write", {8'h0, b}, 16'h0010);
    rd8(4'd8, b); chk("R11 i kept", {8'h0, b}, 16'h0042);

    // R1: reset clears bank selection, keeps data
    xm(); xa();
    rst = 1; tick(); tick(); rst = 0;
    rd16(3'd0, w); chk("R1 bc bank", w, 16'h5AB2);
    rd16(3'd3, w); chk("R1 af bank", w, 16'h3C18);
    rd16(3'd7, w); chk("R1 pc again", w, 16'h0000);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule